// File: doc/BRIEF.md
# Pin Interrupt and Wake Detector

This block sits behind one general-purpose pin and turns its already-filtered input level into two sticky status bits: an interrupt status and a wake status. Software picks a trigger through a level/edge select and a two-bit polarity field, and the chosen trigger is applied to the pin every clock.

Interrupt status is produced only while the interrupt enable is set. A separate unmask control decides only whether a set status is passed on as the pending output. Wake status is produced only when the system is in one of three low-power states and the wake-enable bit for that state is set. Software clears each status by pulsing a write-one-to-clear strobe. If a new event and a clear land in the same cycle, the event wins.

A controller collects the pending output of many instances into one interrupt line. Register decoding and input debouncing live outside this block.

Top module: `pin_event_detector`

## Requirements
- R1: While reset is asserted, and in the first clock after it is released, `int_status`, `wake_status` and `irq_pending` are all 0.
- R2: With `level_mode`=1 and `polarity`=2'b00, interrupt status is set on every clock where `pin_level` is 1. A clear pulse given while the pin stays high leaves the status at 1.
- R3: With `level_mode`=1 and `polarity`=2'b01, interrupt status is set on every clock where `pin_level` is 0.
- R4: With `level_mode`=0 and `polarity`=2'b00, only a 0-to-1 change of `pin_level` between two clocks sets the status. Holding the pin high after a clear does not set it again.
- R5: With `level_mode`=0 and `polarity`=2'b01, only a 1-to-0 change of `pin_level` sets the status.
- R6: With `level_mode`=0 and `polarity`=2'b10, a change in either direction sets the status. `polarity`=2'b10 in level mode never sets a status, and `polarity`=2'b11 never sets one in either mode.
- R7: While `int_en` is 0, `int_status` is never set.
- R8: `irq_pending` is 1 exactly when `irq_unmask` is 1 and at least one of `int_status` or `wake_status` is 1. With `irq_unmask`=0, status bits are still set but `irq_pending` stays 0.
- R9: `wake_status` is set by a trigger event only when the matching `wake_en` bit is set for the current `sleep_state`: state 1 uses bit 0, state 2 uses bit 1 and state 3 uses bit 2. `sleep_state`=0 (running) never sets it.
- R10: `clr_int` clears only `int_status` and `clr_wake` clears only `wake_status`. Each status otherwise holds its value. When an event and a clear meet in the same clock, the status stays 1.
- R11: The first clock after reset never counts as an edge, whatever level the pin held during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_level | input | 1 | Filtered pin input level |
| level_mode | input | 1 | 1 selects level sensing, 0 selects edge sensing |
| polarity | input | 2 | 00 high/rising, 01 low/falling, 10 both edges, 11 none |
| int_en | input | 1 | Allows interrupt status to be generated |
| irq_unmask | input | 1 | 1 passes a set status on to `irq_pending` |
| wake_en | input | NUM_WAKE | Wake enable for each low-power state |
| sleep_state | input | SLP_W | 0 running, k selects low-power state k |
| clr_int | input | 1 | Write-one strobe that clears the interrupt status |
| clr_wake | input | 1 | Write-one strobe that clears the wake status |
| int_status | output | 1 | Sticky interrupt status |
| wake_status | output | 1 | Sticky wake status |
| irq_pending | output | 1 | Unmasked pending indication |

## Verification
The assertions assume that `pin_level` is already synchronous to `clk`. They also assume that configuration inputs change only between clock edges and are seen as stable at each edge. The bench meets both by driving every input on the falling edge. It changes the trigger configuration only while the pin holds a known level, so any edge the bench expects comes from a pin transition it placed itself. The bench also takes care to give `sleep_state` only encodings that have a matching wake-enable bit.

// File: rtl/pin_event_detector.sv
`timescale 1ns/1ps
module pin_event_detector #(
  parameter int NUM_WAKE = 3,
  parameter int POL_W    = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             pin_level,
  input  logic                             level_mode,
  input  logic [POL_W-1:0]                 polarity,
  input  logic                             int_en,
  input  logic                             irq_unmask,
  input  logic [NUM_WAKE-1:0]              wake_en,
  input  logic [$clog2(NUM_WAKE+1)-1:0]    sleep_state,
  input  logic                             clr_int,
  input  logic                             clr_wake,
  output logic                             int_status,
  output logic                             wake_status,
  output logic                             irq_pending
);
  localparam int SLP_W = $clog2(NUM_WAKE + 1);
  localparam logic [POL_W-1:0] POL_HIGH = POL_W'(0);
  localparam logic [POL_W-1:0] POL_LOW  = POL_W'(1);
  localparam logic [POL_W-1:0] POL_BOTH = POL_W'(2);

  logic prev_q, primed_q, int_q, wake_q;
  logic trig, wake_armed;

  wire rise = primed_q &  pin_level & ~prev_q;
  wire fall = primed_q & ~pin_level &  prev_q;

  always_comb begin
    trig = 1'b0;
    if (level_mode) begin
      if (polarity == POL_HIGH)     trig = pin_level;
      else if (polarity == POL_LOW) trig = ~pin_level;
    end else begin
      if (polarity == POL_HIGH)      trig = rise;
      else if (polarity == POL_LOW)  trig = fall;
      else if (polarity == POL_BOTH) trig = rise | fall;
    end
  end

  always_comb begin
    wake_armed = 1'b0;
    for (int k = 0; k < NUM_WAKE; k++)
      if (sleep_state == SLP_W'(k + 1) && wake_en[k]) wake_armed = 1'b1;
  end

  wire int_set  = trig & int_en;
  wire wake_set = trig & wake_armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      primed_q <= 1'b0;
      int_q    <= 1'b0;
      wake_q   <= 1'b0;
    end else begin
      prev_q   <= pin_level;
      primed_q <= 1'b1;
      int_q    <= int_set  | (int_q  & ~clr_int);
      wake_q   <= wake_set | (wake_q & ~clr_wake);
    end
  end

  assign int_status  = int_q;
  assign wake_status = wake_q;
  assign irq_pending = irq_unmask & (int_q | wake_q);

  AST_NO_INT_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_en && !int_status) |=> !int_status); // R7
  AST_INT_ROSE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_status) |-> $past(int_en)); // R7
  AST_NO_WAKE_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_state == '0 && !wake_status) |=> !wake_status); // R9
  AST_INT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (int_status && !clr_int) |=> int_status); // R10
  AST_WAKE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_status && !clr_wake) |=> wake_status); // R10
  AST_LEVEL_BOTH_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (level_mode && polarity == POL_BOTH && !int_status) |=> !int_status); // R6
  AST_RISE_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(int_status) && !$past(level_mode) && $past(polarity) == POL_HIGH)
      |-> $past(pin_level)); // R4
  AST_PENDING_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> irq_unmask); // R8
endmodule

// File: tb/pin_event_detector_tb.sv
`timescale 1ns/1ps
module pin_event_detector_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pin = 1'b0, lvl = 1'b0, ie = 1'b1, um = 1'b1, ci = 1'b0, cw = 1'b0;
  logic [1:0] pol = 2'b00, slp = 2'b00;
  logic [2:0] we = 3'b000;
  logic int_s, wake_s, pend;
  int checks = 0, failures = 0;
  logic [2:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_event_detector u_dut (
    .clk(clk), .rst_n(rst_n), .pin_level(pin), .level_mode(lvl), .polarity(pol),
    .int_en(ie), .irq_unmask(um), .wake_en(we), .sleep_state(slp),
    .clr_int(ci), .clr_wake(cw),
    .int_status(int_s), .wake_status(wake_s), .irq_pending(pend));

  task automatic compare(input logic [2:0] e, input string r);
    checks++;
    if ({int_s, wake_s, pend} !== e) begin
      failures++;
      $display("FAIL %s: {int,wake,pend} actual=%b expected=%b", r, {int_s, wake_s, pend}, e);
    end
  endtask

  task automatic step(input logic p, input logic c_i, input logic c_w,
                      input logic [2:0] e, input string r);
    pin = p; ci = c_i; cw = c_w;
    exp_q.push_back(e);
    tag_q.push_back(r);
    @(negedge clk);
  endtask

  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
  end

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    pin = 1'b1;
    repeat (3) @(negedge clk);
    compare(3'b000, "R1 in reset");
    rst_n = 1'b1;
    step(1, 0, 0, 3'b000, "R11 no edge from reset level");
    step(1, 0, 0, 3'b000, "R1 idle after reset");
    step(0, 0, 0, 3'b000, "R4 falling ignored");
    step(1, 0, 0, 3'b101, "R4 rising sets");
    step(1, 1, 0, 3'b000, "R10 clear");
    step(1, 0, 0, 3'b000, "R4 held high no retrigger");
    step(0, 0, 0, 3'b000, "R4 fall ignored");
    um = 1'b0;
    step(1, 0, 0, 3'b100, "R8 masked status set");
    step(1, 0, 0, 3'b100, "R8 masked hold");
    um = 1'b1;
    step(1, 0, 0, 3'b101, "R8 unmask delivers");
    step(1, 1, 0, 3'b000, "R10 clear");
    pol = 2'b01;
    step(0, 0, 0, 3'b101, "R5 falling sets");
    step(0, 1, 0, 3'b000, "R10 clear");
    step(1, 0, 0, 3'b000, "R5 rising ignored");
    step(0, 1, 0, 3'b101, "R10 set wins over clear");
    step(0, 1, 0, 3'b000, "R10 clear");
    pol = 2'b10;
    step(1, 0, 0, 3'b101, "R6 both rising");
    step(1, 1, 0, 3'b000, "R10 clear");
    step(0, 0, 0, 3'b101, "R6 both falling");
    step(0, 1, 0, 3'b000, "R10 clear");
    pol = 2'b11;
    step(1, 0, 0, 3'b000, "R6 code 11 edge rise");
    step(0, 0, 0, 3'b000, "R6 code 11 edge fall");
    lvl = 1'b1; pol = 2'b00;
    step(0, 0, 0, 3'b000, "R2 level low inactive");
    step(1, 0, 0, 3'b101, "R2 level high sets");
    step(1, 1, 0, 3'b101, "R2 reasserts while high");
    step(0, 1, 0, 3'b000, "R10 clear after level drops");
    step(0, 0, 0, 3'b000, "R2 stays clear");
    pol = 2'b01;
    step(0, 0, 0, 3'b101, "R3 level low sets");
    step(1, 1, 0, 3'b000, "R10 clear");
    step(1, 0, 0, 3'b000, "R3 high inactive");
    pol = 2'b10;
    step(0, 0, 0, 3'b000, "R6 both in level mode");
    step(1, 0, 0, 3'b000, "R6 both in level mode");
    step(1, 0, 0, 3'b000, "R6 both in level mode steady");
    lvl = 1'b0; pol = 2'b00; ie = 1'b0;
    step(0, 0, 0, 3'b000, "R7 disabled");
    step(1, 0, 0, 3'b000, "R7 rising while disabled");
    ie = 1'b1;
    step(1, 0, 0, 3'b000, "R7 enable later no stale event");
    ie = 1'b0; slp = 2'd0; we = 3'b111;
    step(0, 0, 0, 3'b000, "R9 running");
    step(1, 0, 0, 3'b000, "R9 running no wake");
    slp = 2'd1; we = 3'b001;
    step(0, 0, 0, 3'b000, "R9 state1");
    step(1, 0, 0, 3'b011, "R9 state1 bit0 wakes");
    step(1, 0, 1, 3'b000, "R10 wake clear");
    slp = 2'd2;
    step(0, 0, 0, 3'b000, "R9 state2");
    step(1, 0, 0, 3'b000, "R9 state2 bit1 off");
    we = 3'b010;
    step(0, 0, 0, 3'b000, "R9 state2");
    step(1, 0, 0, 3'b011, "R9 state2 bit1 wakes");
    step(1, 1, 0, 3'b011, "R10 clr_int leaves wake");
    step(1, 0, 1, 3'b000, "R10 wake clear");
    slp = 2'd3; we = 3'b100;
    step(0, 0, 0, 3'b000, "R9 state3");
    step(1, 0, 0, 3'b011, "R9 state3 bit2 wakes");
    um = 1'b0;
    step(1, 0, 0, 3'b010, "R8 wake masked");
    step(1, 0, 1, 3'b000, "R10 wake clear");
    ie = 1'b1;
    step(0, 0, 0, 3'b000, "R9 prep");
    step(1, 0, 0, 3'b110, "R8 both set masked");
    um = 1'b1;
    step(1, 0, 0, 3'b111, "R8 both set delivered");
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule